// File: doc/BRIEF.md
# Card Socket Status-Change Interrupt Unit

This block watches the live signal lines of one removable-card socket (two card-detect lines, two battery-detect lines, ready/busy, write protect, wait, power-good and the card's I/O interrupt request). Each line crosses into the clock domain through a two-flop synchronizer. Whenever a watched line changes level, a sticky change flag is latched. An access-timeout pulse from the surrounding logic latches a sticky flag of its own. Software reads the flags in a 16-bit status word and clears them by writing ones to their positions.

Per-source enables mask the flags into a summary status-change interrupt. That interrupt and the card's I/O interrupt each have a select bit that steers them to one of two active-low host interrupt lines. A memory-plus-I/O mode makes the top status bit report the card's interrupt request, and lets that request drive a host line. A diagnostic mode replaces the watched pin levels with values held in a diagnostic register, so software can exercise the change logic with no card present.

Software reaches three registers through a plain register port with a 2-bit address: control (0), diagnostic (1) and status (2).

Top module: `card_status_irq`

## Requirements
- R1: After reset, the status word's bits 15..8 are zero, the control and diagnostic registers read zero, and both host interrupt lines are high (inactive).
- R2: Status bits 7..0 show the synchronized levels of, from bit 7 down to bit 0: card detect 2, card detect 1, battery detect 2, battery detect 1, ready, write protect, wait and power-good. A pin change shows up after two rising clock edges.
- R3: A level change in either direction latches a sticky flag. The flag positions are: bit 13 for either card-detect line, bit 12 for battery detect 2, bit 11 for battery detect 1, bit 10 for ready and bit 9 for write protect. A flag stays set until it is cleared, and it appears one edge after the change is visible in the live bits.
- R4: A status write clears each flag in bits 13..8 whose written bit is 1 and leaves the others alone. If a change event for a flag falls in the same cycle as its clear, the flag stays set.
- R5: A one-cycle pulse on `access_timeout` sets sticky flag bit 8 at the next edge.
- R6: Control bits 9..4 enable the flags of bits 13..8 respectively (control bit 4+i enables status bit 8+i). Status bit 14 is the OR of all enabled pending flags.
- R7: Control bit 1 routes the status-change interrupt to host line 0 (value 0) or line 1 (value 1), and control bit 2 routes the card I/O interrupt the same way. A host line is driven low while any interrupt routed to it is active.
- R8: Control bit 0 selects memory-plus-I/O mode. In memory-only mode status bit 15 reads 0. In I/O mode bit 15 shows the synchronized card I/O request. The I/O interrupt is active only in I/O mode with the I/O enable (control bit 3) set.
- R9: When diagnostic bit 0 is 1, the watched levels come from diagnostic bits instead of the pins: bit 1 drives both card-detect lines, bit 2 battery detect 2, bit 3 battery detect 1, bit 4 ready, bit 5 write protect and bit 6 wait. The override takes effect one edge after the register write, and pin changes on overridden lines are then ignored.
- R10: Status writes do not affect bits 15, 14 or 7..0.
- R11: The control register reads back its bits 9..0 and the diagnostic register its bits 6..0, with all other bits zero. Address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_cd1 | input | 1 | Card detect 1 level |
| pin_cd2 | input | 1 | Card detect 2 level |
| pin_bvd1 | input | 1 | Battery detect 1 level (status-change line in I/O mode) |
| pin_bvd2 | input | 1 | Battery detect 2 level (speaker line in I/O mode) |
| pin_rdy | input | 1 | Ready/busy level (I/O request line in I/O mode) |
| pin_wp | input | 1 | Write protect level (16-bit I/O line in I/O mode) |
| pin_wait | input | 1 | Wait level |
| pin_pwr | input | 1 | Power-good level |
| pin_io_req | input | 1 | Card I/O interrupt request, active high |
| access_timeout | input | 1 | One-cycle access-timeout pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 diagnostic, 2 status) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| host_irq_n | output | 2 | Host interrupt lines, active low |

## Verification
A pin change reaches the live bits after two rising edges and the sticky flag after three, so the bench drives inputs on falling edges and samples live bits two falling edges later and flags one falling edge after that. Register writes take effect at the edge inside the write task. A diagnostic override therefore shows in the live bits when the task returns, and the flags it causes one falling edge later. Read data, the summary bit and the host lines follow the registers with no further delay, so they are checked directly after the write that changes them. For the collision case, the clear is timed to land on the same edge as the third edge after a pin change.

// File: rtl/csi_pkg.sv
package csi_pkg;
    localparam int DATA_W  = 16;
    localparam int LIVE_W  = 8;
    localparam int WATCH_W = 6;
    localparam int FLAG_W  = 6;
    localparam int SYNC_W  = LIVE_W + 1;
    localparam int LINES   = 2;
    localparam int FLAG_LO = 8;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_DIAG = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    typedef struct packed {
        logic [FLAG_W-1:0] en;
        logic              io_ie;
        logic              io_route;
        logic              sc_route;
        logic              io_mode;
    } ctrl_t;

    typedef struct packed {
        logic wait_v;
        logic wp;
        logic rdy;
        logic bvd1;
        logic bvd2;
        logic cd;
        logic en;
    } diag_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int DIAG_W = $bits(diag_t);
endpackage

// File: rtl/csi_sync.sv
module csi_sync #(
    parameter int WIDTH  = 9,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/csi_flags.sv
module csi_flags
    import csi_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WATCH_W-1:0] watch,
    input  logic               timeout,
    input  logic [FLAG_W-1:0]  clr,
    output logic [FLAG_W-1:0]  flags
);
    // watch order: [5] cd2, [4] cd1, [3] bvd2, [2] bvd1, [1] rdy, [0] wp
    typedef struct packed {
        logic [WATCH_W-1:0] prev;
        logic [FLAG_W-1:0]  flg;
    } fstate_t;

    fstate_t st_d, st_q;
    logic [WATCH_W-1:0] chg;
    logic [FLAG_W-1:0]  set;

    always_comb begin
        chg = watch ^ st_q.prev;
        set = {chg[5] | chg[4], chg[3], chg[2], chg[1], chg[0], timeout};
        st_d.prev = watch;
        st_d.flg  = (st_q.flg & ~clr) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flg;

    for (genvar i = 0; i < FLAG_W; i++) begin : g_chk
        // R3: a pending flag with no clear stays pending
        p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !clr[i]) |=> flags[i]);
        // R4: a set event beats a simultaneous clear
        p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (set[i] && clr[i]) |=> flags[i]);
    end
endmodule

// File: rtl/card_status_irq.sv
module card_status_irq
    import csi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_cd1,
    input  logic              pin_cd2,
    input  logic              pin_bvd1,
    input  logic              pin_bvd2,
    input  logic              pin_rdy,
    input  logic              pin_wp,
    input  logic              pin_wait,
    input  logic              pin_pwr,
    input  logic              pin_io_req,
    input  logic              access_timeout,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [LINES-1:0]  host_irq_n
);
    typedef struct packed {
        ctrl_t ctrl;
        diag_t diag;
    } rstate_t;

    rstate_t st_d, st_q;

    logic [SYNC_W-1:0] synced;
    logic [LIVE_W-1:0] live;
    logic              io_req_s;
    logic [FLAG_W-1:0] flags;
    logic [FLAG_W-1:0] clr;
    logic              summary;
    logic              io_active;
    logic [DATA_W-1:0] status;

    csi_sync #(.WIDTH(SYNC_W), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({pin_io_req, pin_cd2, pin_cd1, pin_bvd2, pin_bvd1,
                    pin_rdy, pin_wp, pin_wait, pin_pwr}),
        .sync_out (synced)
    );

    assign io_req_s = synced[SYNC_W-1];

    // diagnostic override of the watched lines (power-good is never overridden)
    always_comb begin
        live = synced[LIVE_W-1:0];
        if (st_q.diag.en) begin
            live[7] = st_q.diag.cd;
            live[6] = st_q.diag.cd;
            live[5] = st_q.diag.bvd2;
            live[4] = st_q.diag.bvd1;
            live[3] = st_q.diag.rdy;
            live[2] = st_q.diag.wp;
            live[1] = st_q.diag.wait_v;
        end
    end

    assign clr = (reg_wr && reg_addr == ADDR_STAT)
               ? reg_wdata[FLAG_LO+FLAG_W-1:FLAG_LO] : '0;

    csi_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .watch   (live[7:2]),
        .timeout (access_timeout),
        .clr     (clr),
        .flags   (flags)
    );

    assign summary   = |(flags & st_q.ctrl.en);
    assign io_active = st_q.ctrl.io_mode && st_q.ctrl.io_ie && io_req_s;
    assign status    = {st_q.ctrl.io_mode & io_req_s, summary, flags, live};

    always_comb begin
        st_d = st_q;
        if (reg_wr) begin
            case (reg_addr)
                ADDR_CTRL: st_d.ctrl = ctrl_t'(reg_wdata[CTRL_W-1:0]);
                ADDR_DIAG: st_d.diag = diag_t'(reg_wdata[DIAG_W-1:0]);
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (reg_addr)
            ADDR_CTRL: reg_rdata = {{(DATA_W-CTRL_W){1'b0}}, st_q.ctrl};
            ADDR_DIAG: reg_rdata = {{(DATA_W-DIAG_W){1'b0}}, st_q.diag};
            ADDR_STAT: reg_rdata = status;
            default:   reg_rdata = '0;
        endcase
    end

    for (genvar l = 0; l < LINES; l++) begin : g_line
        assign host_irq_n[l] =
            !((summary   && (st_q.ctrl.sc_route == l[0])) ||
              (io_active && (st_q.ctrl.io_route == l[0])));
    end

    // R6: with every enable off, neither host line may be asserted
    p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.en == '0 && !st_q.ctrl.io_ie) |-> (host_irq_n == '1));
    // R7: a pending summary routed to line 0 pulls that line low
    p_route_sc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status[14] && !st_q.ctrl.sc_route) |-> !host_irq_n[0]);
    // R8: memory-only mode keeps the top status bit at zero
    p_top_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ctrl.io_mode |-> !status[15]);
endmodule

// File: tb/tb_card_status_irq.sv
module tb_card_status_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_cd1 = 0, pin_cd2 = 0, pin_bvd1 = 0, pin_bvd2 = 0;
    logic        pin_rdy = 0, pin_wp = 0, pin_wait = 0, pin_pwr = 0, pin_io_req = 0;
    logic        access_timeout = 0;
    logic        reg_wr = 0;
    logic [1:0]  reg_addr = 0;
    logic [15:0] reg_wdata = 0;
    logic [15:0] reg_rdata;
    logic [1:0]  host_irq_n;

    int n_chk = 0;
    int n_bad = 0;

    card_status_irq dut (.*);

    always #10 clk = ~clk;

    // {ctrl word, expected summary bit, expected host_irq_n}
    localparam logic [18:0] VEC [7] = '{
        {16'h0000, 1'b0, 2'b11},
        {16'h0020, 1'b1, 2'b10},
        {16'h0022, 1'b1, 2'b01},
        {16'h0100, 1'b0, 2'b11},
        {16'h0042, 1'b1, 2'b01},
        {16'h03F0, 1'b1, 2'b10},
        {16'h0010, 1'b0, 2'b11}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(20 * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2, v); chk("R1 status", v, 16'h0000);
        rd(0, v); chk("R1 ctrl", v, 16'h0000);
        rd(1, v); chk("R1 diag", v, 16'h0000);
        chk("R1 irq", {14'd0, host_irq_n}, 16'h0003);

        // R2 live bits, R3 flags one edge later
        pin_cd1 = 1; pin_bvd2 = 1; pin_wait = 1; pin_pwr = 1;
        @(negedge clk);
        rd(2, v); chk("R2 not yet after one edge", v, 16'h0000);
        @(negedge clk);
        rd(2, v); chk("R2 live levels", v, 16'h0063);
        @(negedge clk);
        rd(2, v); chk("R3 cd and bvd2 flags", v, 16'h3063);

        // R4 partial clear, R10 other bits untouched
        wr(2, 16'hE0FF);
        rd(2, v); chk("R4 R10 clear cd only", v, 16'h1063);
        rd(2, v); chk("R3 bvd2 still pending", v & 16'h1000, 16'h1000);
        wr(2, 16'h1000);
        rd(2, v); chk("R4 clear bvd2", v, 16'h0063);

        // pend wp and rdy
        pin_wp = 1; pin_rdy = 1;
        repeat (3) @(negedge clk);
        rd(2, v); chk("R3 wp and rdy flags", v, 16'h066F);

        // R6 R7 table
        for (int i = 0; i < 7; i++) begin
            wr(0, VEC[i][18:3]);
            rd(2, v);
            chk($sformatf("R6 summary vec %0d", i), {15'd0, v[14]}, {15'd0, VEC[i][2]});
            chk($sformatf("R7 irq vec %0d", i), {14'd0, host_irq_n}, {14'd0, VEC[i][1:0]});
        end
        wr(0, 16'h0000);

        // R4 set wins over simultaneous clear (wp flag pending already)
        pin_wp = 0;
        repeat (2) @(negedge clk);
        wr(2, 16'h0200);
        rd(2, v); chk("R4 set wins", v & 16'h0200, 16'h0200);
        wr(2, 16'h0200);
        rd(2, v); chk("R4 clear wp", v & 16'h0200, 16'h0000);

        // R5 timeout pulse
        access_timeout = 1;
        @(negedge clk);
        access_timeout = 0;
        rd(2, v); chk("R5 timeout flag", v & 16'h0100, 16'h0100);

        // R8 I/O mode
        pin_io_req = 1;
        repeat (2) @(negedge clk);
        rd(2, v); chk("R8 top bit zero in memory mode", v & 16'h8000, 16'h0000);
        chk("R8 irq idle in memory mode", {14'd0, host_irq_n}, 16'h0003);
        wr(0, 16'h000D);
        rd(2, v); chk("R8 top bit shows request", v & 16'h8000, 16'h8000);
        chk("R8 R7 io irq on line 1", {14'd0, host_irq_n}, 16'h0001);
        wr(0, 16'h0005);
        chk("R8 io irq needs enable", {14'd0, host_irq_n}, 16'h0003);

        // R9 diagnostic override
        wr(2, 16'hFF00);
        rd(2, v); chk("R9 flags cleared", v & 16'h3F00, 16'h0000);
        wr(1, 16'h0021);
        rd(2, v); chk("R9 live from diag", v & 16'h00FF, 16'h0005);
        @(negedge clk);
        rd(2, v); chk("R9 flags from diag changes", v & 16'h3F00, 16'h3600);
        wr(2, 16'h3F00);
        pin_rdy = 0; pin_wp = 1; pin_cd2 = 1;
        repeat (3) @(negedge clk);
        rd(2, v); chk("R9 pins ignored", v & 16'h3FFF, 16'h0005);

        // R11 readback
        wr(0, 16'hFFFF);
        rd(0, v); chk("R11 ctrl readback", v, 16'h03FF);
        rd(1, v); chk("R11 diag readback", v, 16'h0021);
        rd(3, v); chk("R11 addr 3 zero", v, 16'h0000);

        finish_run();
    end
endmodule